// File: doc/BRIEF.md
# Backup-Mode and Reset Sequencer

This block sits between the supply-monitor reset input, an external warm reset input and the rest of the chip. While the power-good input is low, the chip is in battery backup. A separate always-on timer clock keeps running. The main clock enables are withdrawn, so those clocks sit at their idle high level. Control registers are held in reset. A retention flag tells the memories that their contents must survive. Every class of pins is forced to its own safe state.

When power-good returns, the sequencer works in the timer clock domain. It first restores the main clock enables after a fixed number of timer ticks. It then keeps the register reset applied until the start-up window has elapsed. The register reset is released into the main clock domain through a synchronizer.

During normal operation, the warm reset input only takes effect if it stays low for a minimum number of timer ticks. Shorter pulses are filtered out and change nothing.

Top module: `bkp_reset_sequencer`

## Requirements
- R1: When `por_n` falls, `main_clk_en` goes to 0, `reg_rst_n` goes to 0 and `mem_retain` goes to 1 at once, without waiting for any clock edge.
- R2: `pin_force` holds one 2-bit code per pin class. Bits [1:0] are push-pull outputs, [3:2] tri-state strobe outputs, [5:4] tri-state address/select outputs, [7:6] bidirectional pins and [9:8] inputs. The codes are 00 = pass, 01 = force low, 10 = high impedance. While `mem_retain` is 1 the classes read low, low, low, high impedance, low (10'b0110010101). Otherwise every class reads 00.
- R3: With `por_n` rising between two timer edges, `main_clk_en`, `mem_retain` and `pin_force` keep their backup values through timer edge SYNC_STAGES+RESTORE_TICKS. All three are released together at edge SYNC_STAGES+1+RESTORE_TICKS.
- R4: `reg_rst_n` stays 0 through timer edge SYNC_STAGES+STARTUP_TICKS after `por_n` rises. It goes to 1 on the second `clk` edge after timer edge SYNC_STAGES+1+STARTUP_TICKS, provided `warm_rst_n` is high.
- R5: While `por_n` is high, a `warm_rst_n` low level sampled on QUAL_TICKS or more consecutive timer edges drives `reg_rst_n` low for a time. `reg_rst_n` returns to 1 once `warm_rst_n` is high again. `main_clk_en`, `mem_retain` and `pin_force` do not change.
- R6: A `warm_rst_n` low level sampled on fewer than QUAL_TICKS consecutive timer edges is ignored: `reg_rst_n`, `main_clk_en`, `mem_retain` and `pin_force` do not move.
- R7: If `warm_rst_n` is still low when the start-up window ends, `reg_rst_n` stays 0 until `warm_rst_n` rises.
- R8: `reg_rst_n` is 1 only while `main_clk_en` is 1.
- R9: `reg_rst_n` is 0 whenever `mem_retain` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tmr_clk | input | 1 | Always-on timer clock |
| clk | input | 1 | Ungated main clock root, used for register-reset release |
| por_n | input | 1 | Power-good input; low selects battery backup |
| warm_rst_n | input | 1 | Warm reset request, active low, unqualified |
| main_clk_en | output | 1 | Main clock gate enable; 0 parks those clocks high |
| reg_rst_n | output | 1 | Active-low register reset for the main domain |
| mem_retain | output | 1 | Memory contents must be retained |
| pin_force | output | 10 | Per-class pin override codes |

## Verification
Warm reset pulses are applied at exactly one tick short of the qualification length and at exactly the qualification length. This pins the filter boundary to a single tick. Seeded random pulse lengths on both sides of that boundary are then compared with a predicted reset/no-reset outcome. A monitor also confirms that no clock enable, retention flag or pin override moves during any of these pulses.

The power-up sequence is sampled one timer edge before and one timer edge after each release point. This separates the clock restore point from the later register-reset release. The bench also covers a power loss in the middle of operation and a warm reset held low past the start-up window.

// File: rtl/bkp_pkg.sv
package bkp_pkg;

  localparam int NUM_CLASSES = 5;
  localparam int CODE_W      = 2;

  typedef enum logic [1:0] {
    FORCE_NONE = 2'b00,
    FORCE_LOW  = 2'b01,
    FORCE_HIZ  = 2'b10
  } force_e;

  typedef enum logic [1:0] {
    ST_BACKUP = 2'd0,
    ST_WAKE   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_e;

  // class order: push-pull, tri-state strobes, tri-state address/select,
  // bidirectional, inputs
  function automatic force_e class_backup_code(input int idx);
    force_e code;
    case (idx)
      3:       code = FORCE_HIZ;
      default: code = FORCE_LOW;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/bkp_sync.sv
module bkp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/bkp_warm_qual.sv
module bkp_warm_qual #(
  parameter int QUAL_TICKS = 4
) (
  input  logic tmr_clk,
  input  logic tmr_rst_n,
  input  logic warm_s,
  output logic warm_hit
);

  localparam int QW = $clog2(QUAL_TICKS + 1);

  logic [QW-1:0] qcnt_q, qcnt_d;
  logic          hit_q, hit_d;

  always_comb begin
    qcnt_d = qcnt_q;
    hit_d  = hit_q;
    if (warm_s) begin
      qcnt_d = '0;
      hit_d  = 1'b0;
    end else begin
      if (qcnt_q != QW'(QUAL_TICKS)) begin
        qcnt_d = qcnt_q + QW'(1);
      end
      hit_d = (qcnt_d == QW'(QUAL_TICKS));
    end
  end

  always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
    if (!tmr_rst_n) begin
      qcnt_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      qcnt_q <= qcnt_d;
      hit_q  <= hit_d;
    end
  end

  assign warm_hit = hit_q;

endmodule

// File: rtl/bkp_seq_fsm.sv
module bkp_seq_fsm
  import bkp_pkg::*;
#(
  parameter int RESTORE_TICKS = 10,
  parameter int STARTUP_TICKS = 3277
) (
  input  logic tmr_clk,
  input  logic tmr_rst_n,
  input  logic warm_hit,
  output logic clk_en,
  output logic hold_safe,
  output logic rst_req
);

  localparam int CW = $clog2(STARTUP_TICKS + 1);

  seq_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          req_q, req_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_BACKUP: begin
        st_d  = ST_WAKE;
        cnt_d = '0;
      end
      ST_WAKE: begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_d == CW'(RESTORE_TICKS)) st_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_d == CW'(STARTUP_TICKS)) st_d = ST_RUN;
      end
      default: begin
        cnt_d = cnt_q;
      end
    endcase
    req_d = (st_d != ST_RUN) || warm_hit;
  end

  always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
    if (!tmr_rst_n) begin
      st_q  <= ST_BACKUP;
      cnt_q <= '0;
      req_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign clk_en    = (st_q == ST_SETTLE) || (st_q == ST_RUN);
  assign hold_safe = !clk_en;
  assign rst_req   = req_q;

endmodule

// File: rtl/bkp_force_map.sv
module bkp_force_map
  import bkp_pkg::*;
(
  input  logic                          hold_safe,
  output logic [NUM_CLASSES*CODE_W-1:0] pin_force
);

  for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_class
    localparam force_e SAFE_CODE = class_backup_code(i);
    assign pin_force[i*CODE_W +: CODE_W] = hold_safe ? SAFE_CODE : FORCE_NONE;
  end

endmodule

// File: rtl/bkp_reset_sequencer.sv
module bkp_reset_sequencer
  import bkp_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int RESTORE_TICKS = 10,
  parameter int STARTUP_TICKS = 3277,
  parameter int QUAL_TICKS    = 4
) (
  input  logic        tmr_clk,
  input  logic        clk,
  input  logic        por_n,
  input  logic        warm_rst_n,
  output logic        main_clk_en,
  output logic        reg_rst_n,
  output logic        mem_retain,
  output logic [9:0]  pin_force
);

  logic tmr_rst_n;
  logic warm_s;
  logic warm_hit;
  logic hold_safe;
  logic rst_req;
  logic main_arst_n;

  // timer-domain reset: asserted with por_n, released on timer clock
  bkp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tmr_rst (
    .clk    (tmr_clk),
    .arst_n (por_n),
    .d      (1'b1),
    .q      (tmr_rst_n)
  );

  bkp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_warm_sync (
    .clk    (tmr_clk),
    .arst_n (tmr_rst_n),
    .d      (warm_rst_n),
    .q      (warm_s)
  );

  bkp_warm_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .tmr_clk   (tmr_clk),
    .tmr_rst_n (tmr_rst_n),
    .warm_s    (warm_s),
    .warm_hit  (warm_hit)
  );

  bkp_seq_fsm #(
    .RESTORE_TICKS (RESTORE_TICKS),
    .STARTUP_TICKS (STARTUP_TICKS)
  ) u_fsm (
    .tmr_clk   (tmr_clk),
    .tmr_rst_n (tmr_rst_n),
    .warm_hit  (warm_hit),
    .clk_en    (main_clk_en),
    .hold_safe (hold_safe),
    .rst_req   (rst_req)
  );

  // main-domain register reset: asserted at once, released on clk
  assign main_arst_n = !rst_req;

  bkp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_main_rst (
    .clk    (clk),
    .arst_n (main_arst_n),
    .d      (1'b1),
    .q      (reg_rst_n)
  );

  assign mem_retain = hold_safe;

  bkp_force_map u_force (
    .hold_safe (hold_safe),
    .pin_force (pin_force)
  );

endmodule

// File: rtl/bkp_reset_sequencer_chk.sv
module bkp_reset_sequencer_chk (
  input logic       tmr_clk,
  input logic       clk,
  input logic       por_n,
  input logic       main_clk_en,
  input logic       reg_rst_n,
  input logic       mem_retain,
  input logic [9:0] pin_force
);

  localparam logic [9:0] SAFE_PATTERN = 10'b0110010101;

  assert_retain_holds_reset_R9: assert property (
    @(posedge clk) disable iff (!por_n) mem_retain |-> !reg_rst_n);

  assert_release_needs_clock_R8: assert property (
    @(posedge clk) disable iff (!por_n) reg_rst_n |-> main_clk_en);

  assert_safe_pattern_R2: assert property (
    @(posedge tmr_clk) disable iff (!por_n) mem_retain |-> (pin_force == SAFE_PATTERN));

  assert_joint_release_R3: assert property (
    @(posedge tmr_clk) disable iff (!por_n) $rose(main_clk_en) |-> $fell(mem_retain));

  assert_pass_when_running_R2: assert property (
    @(posedge tmr_clk) disable iff (!por_n) main_clk_en |-> (pin_force == 10'b0));

endmodule

bind bkp_reset_sequencer bkp_reset_sequencer_chk u_chk (
  .tmr_clk     (tmr_clk),
  .clk         (clk),
  .por_n       (por_n),
  .main_clk_en (main_clk_en),
  .reg_rst_n   (reg_rst_n),
  .mem_retain  (mem_retain),
  .pin_force   (pin_force)
);

// File: tb/bkp_reset_sequencer_test.sv
module bkp_reset_sequencer_test;

  localparam int CLK_HALF  = 5;
  localparam int TMR_HALF  = 80;
  localparam int SYNC_N    = 2;
  localparam int RESTORE_N = 10;
  localparam int STARTUP_N = 40;
  localparam int QUAL_N    = 4;
  localparam logic [9:0] SAFE_PAT = 10'b0110010101;

  logic       tmr_clk, clk;
  logic       por_n, warm_rst_n;
  logic       main_clk_en, reg_rst_n, mem_retain;
  logic [9:0] pin_force;

  int  n_checks, n_errors;
  bit  done, mon_on, saw_low, other_chg;

  bkp_reset_sequencer #(
    .SYNC_STAGES   (SYNC_N),
    .RESTORE_TICKS (RESTORE_N),
    .STARTUP_TICKS (STARTUP_N),
    .QUAL_TICKS    (QUAL_N)
  ) uut (
    .tmr_clk     (tmr_clk),
    .clk         (clk),
    .por_n       (por_n),
    .warm_rst_n  (warm_rst_n),
    .main_clk_en (main_clk_en),
    .reg_rst_n   (reg_rst_n),
    .mem_retain  (mem_retain),
    .pin_force   (pin_force)
  );

  initial begin
    clk = 1'b0;
    forever #CLK_HALF clk = ~clk;
  end

  initial begin
    tmr_clk = 1'b0;
    forever #TMR_HALF tmr_clk = ~tmr_clk;
  end

  always @(negedge reg_rst_n) if (mon_on) saw_low = 1'b1;
  always @(main_clk_en or mem_retain or pin_force) if (mon_on) other_chg = 1'b1;

  function automatic bit want_reset(input int len);
    return len >= QUAL_N;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge tmr_clk);
    #2;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  task automatic warm_pulse(input int len, input string req);
    bit exp_rst;
    exp_rst   = want_reset(len);
    saw_low   = 1'b0;
    other_chg = 1'b0;
    mon_on    = 1'b1;
    warm_rst_n = 1'b0;
    step(len);
    warm_rst_n = 1'b1;
    step(QUAL_N + 6);
    #40;
    mon_on = 1'b0;
    chk(saw_low == exp_rst, req, $sformatf("reset seen for pulse %0d", len),
        32'(saw_low), 32'(exp_rst));
    chk(!other_chg, req, "clock/retain/force untouched", 32'(other_chg), 32'd0);
    chk(reg_rst_n == 1'b1, req, "reset released after pulse", 32'(reg_rst_n), 32'd1);
  endtask

  initial begin
    n_checks = 0; n_errors = 0; done = 1'b0;
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4217));
    mon_on = 1'b0; saw_low = 1'b0; other_chg = 1'b0;
    por_n = 1'b0;
    warm_rst_n = 1'b1;
    step(3);
    // R1 / R2: backup state from reset
    chk(main_clk_en == 1'b0, "R1", "clk_en in backup", 32'(main_clk_en), 32'd0);
    chk(reg_rst_n == 1'b0, "R1", "reg reset in backup", 32'(reg_rst_n), 32'd0);
    chk(mem_retain == 1'b1, "R1", "retain in backup", 32'(mem_retain), 32'd1);
    chk(pin_force == SAFE_PAT, "R2", "safe pattern", 32'(pin_force), 32'(SAFE_PAT));

    // R3 / R4: wake sequence
    por_n = 1'b1;
    step(SYNC_N + RESTORE_N);
    chk(main_clk_en == 1'b0, "R3", "clk_en before restore", 32'(main_clk_en), 32'd0);
    chk(mem_retain == 1'b1, "R3", "retain before restore", 32'(mem_retain), 32'd1);
    step(1);
    chk(main_clk_en == 1'b1, "R3", "clk_en at restore", 32'(main_clk_en), 32'd1);
    chk(mem_retain == 1'b0, "R3", "retain at restore", 32'(mem_retain), 32'd0);
    chk(pin_force == 10'b0, "R2", "pass codes when running", 32'(pin_force), 32'd0);
    step(STARTUP_N - RESTORE_N - 1);
    chk(reg_rst_n == 1'b0, "R4", "reset held through window", 32'(reg_rst_n), 32'd0);
    step(1);
    #30;
    chk(reg_rst_n == 1'b1, "R4", "reset released after window", 32'(reg_rst_n), 32'd1);

    // R5 / R6 directed boundary
    warm_pulse(QUAL_N - 1, "R6");
    warm_pulse(QUAL_N, "R5");
    // mixed random lengths on both sides
    for (int i = 0; i < 14; i++) begin
      int len;
      len = 1 + int'($urandom % (QUAL_N + 4));
      warm_pulse(len, want_reset(len) ? "R5" : "R6");
    end

    // R1: power loss while running
    por_n = 1'b0;
    #1;
    chk(main_clk_en == 1'b0, "R1", "clk_en drops at once", 32'(main_clk_en), 32'd0);
    chk(reg_rst_n == 1'b0, "R1", "reset at once", 32'(reg_rst_n), 32'd0);
    chk(mem_retain == 1'b1, "R1", "retain at once", 32'(mem_retain), 32'd1);
    chk(pin_force == SAFE_PAT, "R2", "safe pattern on loss", 32'(pin_force), 32'(SAFE_PAT));

    // R7: warm held low past the start-up window
    step(2);
    warm_rst_n = 1'b0;
    step(1);
    por_n = 1'b1;
    step(SYNC_N + 1 + STARTUP_N + 4);
    #30;
    chk(main_clk_en == 1'b1, "R7", "clocks restored", 32'(main_clk_en), 32'd1);
    chk(reg_rst_n == 1'b0, "R7", "reset held by warm low", 32'(reg_rst_n), 32'd0);
    warm_rst_n = 1'b1;
    step(SYNC_N + 4);
    #30;
    chk(reg_rst_n == 1'b1, "R7", "reset released after warm rise", 32'(reg_rst_n), 32'd1);

    finish_run();
  end

endmodule